// File: doc/BRIEF.md
# Calendar Alarm Comparator with Per-Field Enables

This block raises an alarm when the running calendar reaches a programmed moment. The calendar counter is outside the block. It presents seven BCD fields, a one-cycle second strobe, and a simple register write port. Each alarm field has a compare-enable flag. Software can therefore match any subset of second, minute, hour, weekday, day of month, month and year. This covers a daily alarm, a once-only alarm, or an alarm on a given weekday.

Alarm values are written into staging registers first. They have no effect until a commit write copies all seven staged fields into the active set together, so the block never compares against a half-updated alarm.

A match sets a sticky status flag, and software clears it by writing 1. A separate enable gates the level interrupt output.

Top module: `cal_alarm`

## Requirements
- R1: After reset, every staged and active field has value 0 and its enable clear, the interrupt enable is 0, and both `alarm_status` and `alarm_irq` are 0.
- R2: A write to field address 0..6 (0 sec, 1 min, 2 hour, 3 weekday, 4 day, 5 month, 6 year) changes only the staged copy. Matching keeps using the active set until a commit.
- R3: A write to address 7 with data bit 15 set copies all staged fields (values and enables) into the active set. A write to address 7 with bit 15 clear has no effect.
- R4: When `sec_tick` is high, at least one active field is enabled, and every enabled field equals its time input, `alarm_status` is 1 from the next clock edge. If any enabled field differs, there is no match.
- R5: If no active field is enabled, a tick never sets the status.
- R6: A field whose enable (data bit 15 when staged) is clear is not compared. For example, a disabled weekday does not prevent a match.
- R7: Without `sec_tick`, equal fields do not set the status.
- R8: The status is sticky. A write to address 9 with data bit 0 set clears it at the next edge. A write to address 9 with bit 0 clear leaves it unchanged.
- R9: If a clearing write and a match occur in the same cycle, the status stays 1.
- R10: Address 9 bit 0 … more precisely: address 8 bit 0 is the interrupt enable. `alarm_irq` equals status AND that enable, and a match sets the status even while the enable is 0.
- R11: Only the low field-width bits of a staged value are kept. The widths are 7, 7, 6, 3, 6, 5 and 8 bits for addresses 0..6, so upper data bits never take part in a compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle strobe per calendar second |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hour, BCD |
| cur_wday | input | 3 | Current weekday |
| cur_mday | input | 6 | Current day of month, BCD |
| cur_mon | input | 5 | Current month, BCD |
| cur_year | input | 8 | Current year, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| alarm_status | output | 1 | Sticky match flag |
| alarm_irq | output | 1 | Level interrupt: status AND enable |

## Verification
Every register write, commit and match takes effect at the clock edge that samples it. The new status and interrupt level are therefore due one edge after the stimulus cycle. The bench drives inputs just after a falling edge and lets the reference model predict the state after the next rising edge. It compares both outputs at the following falling edge, exactly one register stage later. A staged value that has not been committed is observed through a tick producing no status change at that same point.

// File: rtl/calm_pkg.sv
package calm_pkg;
    localparam int NUM_FIELDS = 7;
    localparam int VAL_W      = 8;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 16;
    localparam int ENA_BIT    = 15;
    localparam int ADR_COMMIT = 7;
    localparam int ADR_IEN    = 8;
    localparam int ADR_STATUS = 9;

    typedef struct packed {
        logic             en;
        logic [VAL_W-1:0] val;
    } field_t;

    // BCD width of each field, indexed by its register address
    function automatic int field_width(input int idx);
        case (idx)
            0, 1:    return 7;
            2, 4:    return 6;
            3:       return 3;
            5:       return 5;
            default: return 8;
        endcase
    endfunction

    function automatic logic [VAL_W-1:0] field_mask(input int idx);
        return VAL_W'((1 << field_width(idx)) - 1);
    endfunction
endpackage

// File: rtl/calm_regs.sv
module calm_regs
    import calm_pkg::*;
#(
    parameter int NF = NUM_FIELDS,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    output field_t [NF-1:0]    act_o,
    output logic               ien_o
);
    typedef struct packed {
        field_t [NF-1:0] stg;
        field_t [NF-1:0] act;
        logic            ien;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  commit_w;

    assign commit_w = wr_en && (wr_addr == AW'(ADR_COMMIT)) && wr_data[ENA_BIT];

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            for (int i = 0; i < NF; i++) begin
                if (wr_addr == AW'(i)) begin
                    regs_d.stg[i].val = wr_data[VAL_W-1:0] & field_mask(i);
                    regs_d.stg[i].en  = wr_data[ENA_BIT];
                end
            end
            if (wr_addr == AW'(ADR_IEN)) begin
                regs_d.ien = wr_data[0];
            end
        end
        if (commit_w) begin
            regs_d.act = regs_q.stg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign act_o = regs_q.act;
    assign ien_o = regs_q.ien;

    // Active set moves only on a commit write
    assert_active_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_w |=> $stable(act_o));
    assert_commit_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        commit_w |=> (act_o == $past(regs_q.stg)));
endmodule

// File: rtl/calm_match.sv
module calm_match
    import calm_pkg::*;
#(
    parameter int NF = NUM_FIELDS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick_i,
    input  field_t [NF-1:0]             act_i,
    input  logic [NF-1:0][VAL_W-1:0]    cur_i,
    output logic                        match_o
);
    logic [NF-1:0] field_ok;
    logic [NF-1:0] field_on;

    for (genvar g = 0; g < NF; g++) begin : g_field
        assign field_on[g] = act_i[g].en;
        assign field_ok[g] = !act_i[g].en || (act_i[g].val == cur_i[g]);
    end

    assign match_o = tick_i && (|field_on) && (&field_ok);

    assert_match_needs_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> tick_i);
    assert_no_enable_no_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i[0].en == 1'b0 && act_i[1].en == 1'b0 && act_i[2].en == 1'b0 &&
         act_i[NF-1].en == 1'b0 && $countones(field_on) == 0) |-> !match_o);
endmodule

// File: rtl/calm_status.sv
module calm_status (
    input  logic clk,
    input  logic rst_n,
    input  logic match_i,
    input  logic clear_i,
    input  logic ien_i,
    output logic status_o,
    output logic irq_o
);
    typedef struct packed {
        logic status;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (match_i)      st_d.status = 1'b1;
        else if (clear_i) st_d.status = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign irq_o    = st_q.status & ien_i;

    assert_match_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        match_i |=> status_o);
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o && !clear_i) |=> status_o);
    assert_rise_only_on_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o) |-> $past(match_i));
    assert_irq_needs_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> status_o);
endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
    import calm_pkg::*;
#(
    parameter int NF = NUM_FIELDS,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_tick,
    input  logic [6:0]    cur_sec,
    input  logic [6:0]    cur_min,
    input  logic [5:0]    cur_hour,
    input  logic [2:0]    cur_wday,
    input  logic [5:0]    cur_mday,
    input  logic [4:0]    cur_mon,
    input  logic [7:0]    cur_year,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          alarm_status,
    output logic          alarm_irq
);
    field_t [NF-1:0]          act;
    logic                     ien;
    logic                     match;
    logic                     clear_w;
    logic [NF-1:0][VAL_W-1:0] cur;

    assign cur[0] = VAL_W'(cur_sec);
    assign cur[1] = VAL_W'(cur_min);
    assign cur[2] = VAL_W'(cur_hour);
    assign cur[3] = VAL_W'(cur_wday);
    assign cur[4] = VAL_W'(cur_mday);
    assign cur[5] = VAL_W'(cur_mon);
    assign cur[6] = VAL_W'(cur_year);

    assign clear_w = wr_en && (wr_addr == AW'(ADR_STATUS)) && wr_data[0];

    calm_regs #(.NF(NF), .AW(AW), .DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .act_o   (act),
        .ien_o   (ien)
    );

    calm_match #(.NF(NF)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (sec_tick),
        .act_i   (act),
        .cur_i   (cur),
        .match_o (match)
    );

    calm_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .match_i  (match),
        .clear_i  (clear_w),
        .ien_i    (ien),
        .status_o (alarm_status),
        .irq_o    (alarm_irq)
    );

    assert_clear_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_w && !match) |=> !alarm_status);
endmodule

// File: tb/test_cal_alarm.sv
module test_cal_alarm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic [6:0]  cur_sec = '0;
    logic [6:0]  cur_min = '0;
    logic [5:0]  cur_hour = '0;
    logic [2:0]  cur_wday = '0;
    logic [5:0]  cur_mday = '0;
    logic [4:0]  cur_mon = '0;
    logic [7:0]  cur_year = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        alarm_status;
    logic        alarm_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int  m_stg_v[7];
    bit  m_stg_e[7];
    int  m_act_v[7];
    bit  m_act_e[7];
    bit  m_ien;
    bit  m_stat;
    int  cur[7];
    int  wid[7] = '{7, 7, 6, 3, 6, 5, 8};

    always #2.5 clk = ~clk;

    cal_alarm i_cal_alarm (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_wday(cur_wday), .cur_mday(cur_mday), .cur_mon(cur_mon),
        .cur_year(cur_year), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .alarm_status(alarm_status), .alarm_irq(alarm_irq)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit model_match();
        bit any = 0;
        bit all = 1;
        if (!sec_tick) return 0;
        for (int i = 0; i < 7; i++) begin
            if (m_act_e[i]) begin
                any = 1;
                if (m_act_v[i] != cur[i]) all = 0;
            end
        end
        return any && all;
    endfunction

    task automatic drive_time();
        cur_sec  = 7'(cur[0]); cur_min = 7'(cur[1]); cur_hour = 6'(cur[2]);
        cur_wday = 3'(cur[3]); cur_mday = 6'(cur[4]); cur_mon = 5'(cur[5]);
        cur_year = 8'(cur[6]);
    endtask

    // one clock: predict, let the edge happen, compare at the falling edge
    task automatic step(string tag);
        bit m;
        int a;
        drive_time();
        m = model_match();
        if (wr_en) begin
            a = int'(wr_addr);
            if (a == 7 && wr_data[15]) begin
                for (int i = 0; i < 7; i++) begin
                    m_act_v[i] = m_stg_v[i];
                    m_act_e[i] = m_stg_e[i];
                end
            end
            if (a < 7) begin
                m_stg_v[a] = int'(wr_data[7:0]) & ((1 << wid[a]) - 1);
                m_stg_e[a] = wr_data[15];
            end
            if (a == 8) m_ien = wr_data[0];
        end
        if (m) m_stat = 1;
        else if (wr_en && wr_addr == 4'd9 && wr_data[0]) m_stat = 0;
        @(posedge clk);
        @(negedge clk);
        check(tag, "status", int'(alarm_status), int'(m_stat));
        check(tag, "irq", int'(alarm_irq), int'(m_stat && m_ien));
        wr_en = 0; sec_tick = 0; wr_data = '0; wr_addr = '0;
    endtask

    task automatic wr(string tag, int addr, int data);
        wr_en = 1; wr_addr = 4'(addr); wr_data = 16'(data);
        step(tag);
    endtask

    task automatic tick(string tag);
        sec_tick = 1;
        step(tag);
    endtask

    task automatic set_time(int s, int mi, int h, int wd, int d, int mo, int y);
        cur = '{s, mi, h, wd, d, mo, y};
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 7; i++) begin
            m_stg_v[i] = 0; m_stg_e[i] = 0; m_act_v[i] = 0; m_act_e[i] = 0; cur[i] = 0;
        end
        m_ien = 0; m_stat = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state, all-zero time, tick with nothing enabled
        step("R1");
        check("R1", "status after reset", int'(alarm_status), 0);
        tick("R5");
        check("R5", "no field enabled", int'(alarm_status), 0);

        // R2: staged only, no commit
        set_time('h30, 'h15, 'h08, 2, 'h11, 'h06, 'h24);
        wr("R2", 0, 'h8030);
        wr("R2", 1, 'h8015);
        tick("R2");
        check("R2", "staged not active", int'(alarm_status), 0);

        // R3: commit with bit 15 clear
        wr("R3", 7, 'h7FFF);
        tick("R3");
        check("R3", "commit ignored", int'(alarm_status), 0);

        // R3 commit, R7 no tick, R4 match, R10 irq disabled
        wr("R3", 7, 'h8000);
        step("R7");
        check("R7", "no tick", int'(alarm_status), 0);
        tick("R4");
        check("R4", "match sets", int'(alarm_status), 1);
        check("R10", "irq gated off", int'(alarm_irq), 0);

        // R8: sticky, write 0 no effect, write 1 clears
        step("R8");
        wr("R8", 9, 'hFFFE);
        check("R8", "w0 keeps", int'(alarm_status), 1);
        wr("R8", 9, 1);
        check("R8", "w1 clears", int'(alarm_status), 0);

        // R10: irq follows enable
        wr("R10", 8, 1);
        check("R10", "irq low without status", int'(alarm_irq), 0);
        tick("R10");
        check("R10", "irq high", int'(alarm_irq), 1);
        wr("R10", 8, 0);
        check("R10", "irq dropped by enable", int'(alarm_irq), 0);
        wr("R10", 8, 1);
        check("R10", "irq back", int'(alarm_irq), 1);

        // R9: clear and match in same cycle
        sec_tick = 1;
        wr("R9", 9, 1);
        check("R9", "match wins", int'(alarm_status), 1);
        wr("R8", 9, 1);

        // R4: one enabled field differs
        cur[1] = 'h16;
        tick("R4");
        check("R4", "mismatch", int'(alarm_status), 0);
        cur[1] = 'h15;

        // R6: weekday staged disabled vs enabled
        wr("R6", 3, 'h0005);
        wr("R6", 7, 'h8000);
        tick("R6");
        check("R6", "weekday ignored", int'(alarm_status), 1);
        wr("R6", 9, 1);
        wr("R6", 3, 'h8005);
        wr("R6", 7, 'h8000);
        tick("R6");
        check("R6", "weekday differs", int'(alarm_status), 0);
        cur[3] = 5;
        tick("R6");
        check("R6", "weekday equal", int'(alarm_status), 1);
        wr("R6", 9, 1);

        // R11: upper data bits masked off (sec width 7, wday width 3)
        wr("R11", 0, 'h80B0);
        wr("R11", 3, 'h80FD);
        wr("R11", 7, 'h8000);
        tick("R11");
        check("R11", "masked values match", int'(alarm_status), 1);
        wr("R11", 9, 1);

        // full field set including an 8-bit year
        set_time('h59, 'h59, 'h23, 6, 'h31, 'h12, 'h99);
        wr("R4", 0, 'h8059); wr("R4", 1, 'h8059); wr("R4", 2, 'h8023);
        wr("R4", 3, 'h8006); wr("R4", 4, 'h8031); wr("R4", 5, 'h8012);
        wr("R4", 6, 'h8099); wr("R4", 7, 'h8000);
        tick("R4");
        check("R4", "all fields", int'(alarm_status), 1);
        wr("R8", 9, 1);
        cur[6] = 'h98;
        tick("R4");
        check("R4", "year differs", int'(alarm_status), 0);

        // R5: all fields disabled after commit
        for (int i = 0; i < 7; i++) wr("R5", i, 0);
        wr("R5", 7, 'h8000);
        set_time(0, 0, 0, 0, 0, 0, 0);
        tick("R5");
        check("R5", "all disabled", int'(alarm_status), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule